// File: doc/BRIEF.md
# SMBus Management Target with Packet Error Code and Clock Stretching

This block is the serial-bus target inside a managed power unit. It watches open-drain clock and data lines through a synchroniser running on a fast system clock, frames start and stop conditions, bits and bytes, and answers to one 7-bit address. A host writes a register by sending the address with the write bit, a command byte, one data byte and a packet error code. A host reads a register by sending the address with the write bit and the command byte, then a repeated start, the address with the read bit, and then clocking in one data byte followed by a packet error code that the target appends.

Toward the status logic the block offers a plain register port. It gives a write strobe with command and data, a read strobe answered some cycles later by a valid strobe with data, and a combinational "command known" input. It also reports unsupported commands and packet-code mismatches as single-cycle events. When read data is late, the target holds the clock low right after the ninth bit of the read address byte. It never holds the clock longer than a cycle budget derived from the system clock frequency.

Top module: `smb_tgt`

## Requirements
- R1: The block drives each line only through an active-high "pull low" enable. After reset and while the bus is idle, both enables are 0, and the block never produces a start condition.
- R2: A first byte is acknowledged (data line pulled low in the ninth bit) only when bits 7..1 equal the parameter address and bit 0 (read/write flag, 1 = read) is 0. Any other first byte is not acknowledged, and the rest of that transfer is ignored.
- R3: For a write to a known command, the address, command, data and code bytes are all acknowledged. Exactly one write strobe follows, carrying that command and data.
- R4: The packet error code is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0, fed MSB first. It covers every address byte, the command byte and the data byte in bus order, including the read address after a repeated start.
- R5: A write whose code byte mismatches is not acknowledged on that byte, produces no write strobe, and raises one communication-error pulse.
- R6: A read of a known command after a repeated start returns the register port's data MSB first, then the code byte.
- R7: The clock is held low only in the low phase after the ninth bit of the read address, and only while read data is missing. The data line is set before the clock is released.
- R8: A single hold lasts at most LIMIT = CLK_KHZ*STRETCH_US/1000 cycles. If no data has come by then, the byte sent is 0x00 and later transfers work normally.
- R9: A read of an unknown command returns 0x00 with a valid code byte, raises one unsupported-command pulse, and issues no read strobe.
- R10: A write to an unknown command with a correct code is acknowledged, raises one unsupported-command pulse, and issues no write strobe.
- R11: The block changes its data-line enable only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| reg_cmd | output | 8 | Command byte of the current transfer |
| reg_known | input | 1 | Status logic recognises reg_cmd |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rd | output | 1 | One-cycle register read request |
| reg_rvalid | input | 1 | Read data valid |
| reg_rdata | input | 8 | Read data |
| unsup_cmd | output | 1 | One-cycle unsupported-command event |
| comm_err | output | 1 | One-cycle packet-code mismatch event |

## Verification
Bus edges reach the control logic three system cycles after a line moves: two synchroniser flops plus the edge register. Line-level results are therefore due a few cycles after each clock fall. The bench master samples the data line in the middle of the high phase, eight or more cycles after the rise, and waits for the clock line to read high before counting a rise. The write strobe and error events appear one cycle after the fall that ends the code byte's eighth bit. The bench records them on falling system edges and compares the counts only after the stop, so no check depends on an exact cycle.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  // Byte slot of the current transfer
  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_ADDR  = 4'd1,
    PH_CMD   = 4'd2,
    PH_WDATA = 4'd3,
    PH_WPEC  = 4'd4,
    PH_RADDR = 4'd5,
    PH_RDATA = 4'd6,
    PH_RPEC  = 4'd7,
    PH_SKIP  = 4'd8
  } phase_t;

  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_LAST = 4'd7;

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int unsigned STAGES = 2   // must be 2 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_q     = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/smbt_crc8.sv
module smbt_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);

  logic [8:0][7:0] chain;

  assign chain[0] = crc_in;

  generate
    for (genvar gi = 0; gi < 8; gi++) begin : g_bit
      assign chain[gi+1] = {chain[gi][6:0], 1'b0}
                         ^ (POLY & {8{chain[gi][7] ^ data_in[7-gi]}});
    end
  endgenerate

  assign crc_out = chain[8];

endmodule

// File: rtl/smbt_stretch.sv
module smbt_stretch #(
  parameter int unsigned    CW    = 8,
  parameter logic [CW-1:0]  LIMIT = 8'd200   // must be 3 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic scl_oe,
  output logic expire
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!hold_req)           cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign scl_oe = hold_req & (cnt_q != LIMIT);
  // warn two cycles early so the data line settles before release
  assign expire = hold_req & (cnt_q == LIMIT - CW'(2));

  // R8
  stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (cnt_q < LIMIT));

endmodule

// File: rtl/smb_tgt.sv
module smb_tgt
  import smbt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h5A,
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned STRETCH_US  = 24000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CRC_POLY    = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] reg_cmd,
  input  logic       reg_known,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic       reg_rvalid,
  input  logic [7:0] reg_rdata,
  output logic       unsup_cmd,
  output logic       comm_err
);

  localparam longint unsigned LIMIT_CYC =
    (longint'(CLK_KHZ) * longint'(STRETCH_US)) / 64'd1000;
  localparam int unsigned CW = $clog2(LIMIT_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_ff;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s = rst_ff[1];

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t     phase_q, phase_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d;
  logic       sda_q_oe, sda_d_oe;
  logic       skip_q, skip_d;
  logic [7:0] cmd_q, cmd_d, data_q, data_d, crc_q, crc_d;
  logic       nak_q, nak_d;
  logic       wait_q, wait_d, settle_q, settle_d;
  logic [7:0] rdat_q, rdat_d;
  logic       seen_q, seen_d, out_q, out_d;
  logic       wr_q, wr_d, rd_q, rd_d, uns_q, uns_d, err_q, err_d;
  logic [7:0] crc_nx;
  logic       expire, tx_phase, addr_hit;

  smbt_crc8 #(.POLY(CRC_POLY)) u_crc (
    .crc_in(crc_q), .data_in(rx_q), .crc_out(crc_nx)
  );

  smbt_stretch #(.CW(CW), .LIMIT(CW'(LIMIT_CYC))) u_stretch (
    .clk(clk), .rst_n(rst_s), .hold_req(wait_q | settle_q),
    .scl_oe(scl_oe), .expire(expire)
  );

  assign tx_phase = (phase_q == PH_RDATA) || (phase_q == PH_RPEC);
  assign addr_hit = (rx_q[7:1] == TGT_ADDR);

  always_comb begin
    phase_d  = phase_q;  bit_d  = bit_q;   rx_d   = rx_q;   tx_d  = tx_q;
    sda_d_oe = sda_q_oe; skip_d = skip_q;  cmd_d  = cmd_q;  data_d = data_q;
    crc_d    = crc_q;    nak_d  = nak_q;   wait_d = wait_q; settle_d = 1'b0;
    rdat_d   = rdat_q;   seen_d = seen_q;  out_d  = out_q;
    wr_d = 1'b0; rd_d = 1'b0; uns_d = 1'b0; err_d = 1'b0;

    if (out_q && reg_rvalid) begin
      rdat_d = reg_rdata;
      seen_d = 1'b1;
      out_d  = 1'b0;
    end

    if (stop_det) begin
      phase_d  = PH_IDLE;
      sda_d_oe = 1'b0;
      wait_d   = 1'b0;
    end else if (start_det) begin
      if (phase_q == PH_WDATA && bit_q == 4'd0) begin
        phase_d = PH_RADDR;
      end else begin
        phase_d = PH_ADDR;
        crc_d   = 8'h00;
      end
      bit_d    = 4'd0;
      skip_d   = 1'b1;
      sda_d_oe = 1'b0;
      wait_d   = 1'b0;
    end else if (wait_q) begin
      if (seen_q) begin
        tx_d     = rdat_q;
        sda_d_oe = ~rdat_q[7];
        wait_d   = 1'b0;
        settle_d = 1'b1;
      end else if (expire) begin
        tx_d     = 8'h00;
        sda_d_oe = 1'b1;
        wait_d   = 1'b0;
        settle_d = 1'b1;
        out_d    = 1'b0;
      end
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_q < BIT_ACK) rx_d = {rx_q[6:0], sda_q};
        else if (tx_phase)   nak_d = sda_q;
      end else if (scl_fall) begin
        if (skip_q) begin
          skip_d = 1'b0;
        end else if (bit_q == BIT_LAST) begin
          bit_d    = BIT_ACK;
          sda_d_oe = 1'b0;
          nak_d    = 1'b1;
          case (phase_q)
            PH_ADDR: if (addr_hit && !rx_q[0]) begin
              sda_d_oe = 1'b1; nak_d = 1'b0; crc_d = crc_nx;
            end
            PH_CMD: begin
              sda_d_oe = 1'b1; nak_d = 1'b0; crc_d = crc_nx; cmd_d = rx_q;
            end
            PH_WDATA: begin
              sda_d_oe = 1'b1; nak_d = 1'b0; crc_d = crc_nx; data_d = rx_q;
            end
            PH_WPEC: if (rx_q == crc_q) begin
              sda_d_oe = 1'b1; nak_d = 1'b0;
              if (reg_known) wr_d = 1'b1;
              else           uns_d = 1'b1;
            end else begin
              err_d = 1'b1;
            end
            PH_RADDR: if (addr_hit && rx_q[0]) begin
              sda_d_oe = 1'b1; nak_d = 1'b0; crc_d = crc_nx;
              if (reg_known) begin
                rd_d = 1'b1; out_d = 1'b1; seen_d = 1'b0;
              end else begin
                rdat_d = 8'h00; seen_d = 1'b1; uns_d = 1'b1;
              end
            end
            PH_RDATA: crc_d = crc_nx;
            default: ;
          endcase
        end else if (bit_q == BIT_ACK) begin
          bit_d    = 4'd0;
          sda_d_oe = 1'b0;
          case (phase_q)
            PH_ADDR:  phase_d = nak_q ? PH_SKIP : PH_CMD;
            PH_CMD:   phase_d = PH_WDATA;
            PH_WDATA: phase_d = PH_WPEC;
            PH_RADDR: if (nak_q) begin
              phase_d = PH_SKIP;
            end else begin
              phase_d = PH_RDATA;
              if (seen_q) begin
                tx_d     = rdat_q;
                sda_d_oe = ~rdat_q[7];
              end else begin
                wait_d = 1'b1;
              end
            end
            PH_RDATA: if (nak_q) begin
              phase_d = PH_SKIP;
            end else begin
              phase_d  = PH_RPEC;
              tx_d     = crc_q;
              sda_d_oe = ~crc_q[7];
            end
            default:  phase_d = PH_SKIP;
          endcase
        end else begin
          bit_d = bit_q + 4'd1;
          if (tx_phase) begin
            tx_d     = {tx_q[6:0], 1'b0};
            sda_d_oe = ~tx_q[6];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase_q  <= PH_IDLE; bit_q  <= 4'd0;  rx_q   <= 8'h00; tx_q <= 8'h00;
      sda_q_oe <= 1'b0;    skip_q <= 1'b0;  cmd_q  <= 8'h00; data_q <= 8'h00;
      crc_q    <= 8'h00;   nak_q  <= 1'b1;  wait_q <= 1'b0;  settle_q <= 1'b0;
      rdat_q   <= 8'h00;   seen_q <= 1'b0;  out_q  <= 1'b0;
      wr_q <= 1'b0; rd_q <= 1'b0; uns_q <= 1'b0; err_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;  bit_q  <= bit_d;  rx_q   <= rx_d;   tx_q <= tx_d;
      sda_q_oe <= sda_d_oe; skip_q <= skip_d; cmd_q  <= cmd_d;  data_q <= data_d;
      crc_q    <= crc_d;    nak_q  <= nak_d;  wait_q <= wait_d; settle_q <= settle_d;
      rdat_q   <= rdat_d;   seen_q <= seen_d; out_q  <= out_d;
      wr_q <= wr_d; rd_q <= rd_d; uns_q <= uns_d; err_q <= err_d;
    end
  end

  assign sda_oe    = sda_q_oe;
  assign reg_cmd   = cmd_q;
  assign reg_wdata = data_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
  assign unsup_cmd = uns_q;
  assign comm_err  = err_q;

  // R11
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_q);

  // R7
  stretch_slot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(scl_oe) |-> (phase_q == PH_RDATA && bit_q == 4'd0));

  // R3
  commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    reg_wr |-> (phase_q == PH_WPEC && bit_q == BIT_ACK && sda_oe));

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({reg_wr, reg_rd, unsup_cmd, comm_err}));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (phase_q == PH_IDLE) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/smb_tgt_bench.sv
`timescale 1ns/1ps
module smb_tgt_bench;

  localparam int         Q     = 8;
  localparam logic [6:0] ADDR  = 7'h5A;
  localparam int         LIMIT = 200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_ln, sda_ln;
  logic scl_oe, sda_oe, reg_wr, reg_rd, unsup_cmd, comm_err, reg_known;
  logic [7:0] reg_cmd, reg_wdata;
  logic reg_rvalid = 1'b0;
  logic [7:0] reg_rdata = 8'h00;

  assign scl_ln    = m_scl & ~scl_oe;
  assign sda_ln    = m_sda & ~sda_oe;
  assign reg_known = (reg_cmd < 8'h80);

  smb_tgt #(.TGT_ADDR(ADDR), .CLK_KHZ(200000), .STRETCH_US(1)) u_smb_tgt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_cmd(reg_cmd), .reg_known(reg_known),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .unsup_cmd(unsup_cmd), .comm_err(comm_err)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, uns_cnt = 0, err_cnt = 0, quiet_viol = 0;
  logic [7:0] last_cmd = 8'h00, last_dat = 8'h00;
  int lat = 0, rd_left = 0, max_str = 0;
  logic rd_busy = 1'b0;
  logic [7:0] rd_val = 8'h00;
  logic done = 1'b0;
  logic scl_prev = 1'b1, sda_oe_prev = 1'b0;

  // monitor and register-side model, away from the active edge
  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; last_cmd = reg_cmd; last_dat = reg_wdata; end
    if (reg_rd) rd_cnt++;
    if (unsup_cmd) uns_cnt++;
    if (comm_err) err_cnt++;
    if (rst_n && (sda_oe !== sda_oe_prev) && scl_ln && scl_prev) quiet_viol++;
    scl_prev = scl_ln; sda_oe_prev = sda_oe;
    reg_rvalid = 1'b0;
    if (rd_busy) begin
      if (rd_left == 0) begin reg_rvalid = 1'b1; reg_rdata = rd_val; rd_busy = 1'b0; end
      else rd_left--;
    end
    if (reg_rd && lat >= 0) begin rd_busy = 1'b1; rd_left = lat; rd_val = reg_cmd ^ 8'hA5; end
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic clk_high();
    int w = 0;
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_ln !== 1'b1) begin @(negedge clk); w++; end
    if (w > max_str) max_str = w;
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qwait(); clk_high(); qwait(); qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; qwait(); clk_high(); qwait(); b = sda_ln; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; qwait(); clk_high(); qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); clk_high(); qwait(); m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin recv_bit(x); b[i] = x; end
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] dat,
                          input logic corrupt, output logic [3:0] acks);
    logic [7:0] pec;
    pec = crc8(crc8(crc8(8'h00, {a, 1'b0}), cmd), dat) ^ {7'd0, corrupt};
    bus_start();
    send_byte({a, 1'b0}, acks[3]);
    send_byte(cmd, acks[2]);
    send_byte(dat, acks[1]);
    send_byte(pec, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [2:0] acks,
                         output logic [7:0] dat, output logic [7:0] pec);
    max_str = 0;
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    bus_rstart();
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(dat, 1'b1);
    recv_byte(pec, 1'b0);
    bus_stop();
  endtask

  function automatic logic [7:0] rd_pec(input logic [7:0] cmd, input logic [7:0] dat);
    return crc8(crc8(crc8(crc8(8'h00, {ADDR, 1'b0}), cmd), {ADDR, 1'b1}), dat);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] wa;
    logic [2:0] ra;
    logic [7:0] d, p;
    logic a1;
    int w0, u0, r0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state, lines released
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset enables", {scl_oe, sda_oe}, 0);
    chk(wr_cnt + rd_cnt + uns_cnt + err_cnt == 0, "R1 no events", wr_cnt + rd_cnt, 0);

    // R2: wrong address, then own address with read flag first
    w0 = wr_cnt;
    do_write(7'h2C, 8'h11, 8'h22, 1'b0, wa);
    chk(wa[3] == 1'b0, "R2 foreign address nack", wa, 0);
    chk(wr_cnt == w0, "R2 foreign address no write", wr_cnt, w0);
    bus_start(); send_byte({ADDR, 1'b1}, a1); bus_stop();
    chk(a1 == 1'b0, "R2 read flag in first byte nack", a1, 0);

    // R3, R4: write sweep
    for (int i = 0; i < 12; i++) begin
      logic [7:0] c, v;
      c = 8'h10 + 8'(i * 5);
      v = 8'(i * 37 + 3);
      w0 = wr_cnt;
      do_write(ADDR, c, v, 1'b0, wa);
      chk(wa == 4'hF, "R3/R4 write acks", wa, 4'hF);
      chk(wr_cnt == w0 + 1 && last_cmd == c && last_dat == v, "R3 write strobe",
          {last_cmd, last_dat}, {c, v});
    end

    // R5: corrupted code byte
    w0 = wr_cnt; r0 = err_cnt;
    do_write(ADDR, 8'h15, 8'h5C, 1'b1, wa);
    chk(wa == 4'b1110, "R5 bad code nack", wa, 4'b1110);
    chk(err_cnt == r0 + 1 && wr_cnt == w0, "R5 error pulse, no write", err_cnt, r0 + 1);

    // R10: unknown command write
    w0 = wr_cnt; u0 = uns_cnt;
    do_write(ADDR, 8'hC3, 8'h77, 1'b0, wa);
    chk(wa == 4'hF, "R10 unknown write acked", wa, 4'hF);
    chk(uns_cnt == u0 + 1 && wr_cnt == w0, "R10 unsupported pulse, no write", uns_cnt, u0 + 1);

    // R6, R7, R4, R11: read sweep with short and long latency
    for (int i = 0; i < 10; i++) begin
      logic [7:0] c;
      c = 8'h20 + 8'(i * 7);
      lat = (i < 6) ? i * 3 : 100 + i * 5;
      do_read(c, ra, d, p);
      chk(ra == 3'b111, "R6 read acks", ra, 3'b111);
      chk(d == (c ^ 8'hA5), "R6/R11 read data", d, c ^ 8'hA5);
      chk(p == rd_pec(c, c ^ 8'hA5), "R4 read code byte", p, rd_pec(c, c ^ 8'hA5));
      if (lat >= 100) chk(max_str > 0, "R7 hold while data missing", max_str, 1);
      else            chk(max_str == 0, "R7 no hold when data ready", max_str, 0);
    end

    // R9: unknown command read
    lat = 0; u0 = uns_cnt; r0 = rd_cnt;
    do_read(8'h9E, ra, d, p);
    chk(d == 8'h00, "R9 unknown read data", d, 0);
    chk(p == rd_pec(8'h9E, 8'h00), "R9 unknown read code", p, rd_pec(8'h9E, 8'h00));
    chk(uns_cnt == u0 + 1 && rd_cnt == r0, "R9 pulse, no read strobe", uns_cnt, u0 + 1);

    // R8: data never arrives
    lat = -1;
    do_read(8'h33, ra, d, p);
    chk(d == 8'h00, "R8 expired read data", d, 0);
    chk(max_str <= LIMIT && max_str >= LIMIT - 20, "R8 hold length", max_str, LIMIT);
    chk(p == rd_pec(8'h33, 8'h00), "R8 expired read code", p, rd_pec(8'h33, 8'h00));
    lat = 2;
    do_read(8'h41, ra, d, p);
    chk(d == (8'h41 ^ 8'hA5) && max_str == 0, "R8 recovery read", d, 8'h41 ^ 8'hA5);

    // R11: data enable only moved with clock low; R1: idle released
    chk(quiet_viol == 0, "R11 data enable moved with clock high", quiet_viol, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 idle enables", {scl_oe, sda_oe}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule